// File: doc/BRIEF.md
# Byte-Window SPI Command Engine

This block is a host-side SPI master that software drives through eight byte-wide register offsets. Software places a command opcode, up to three address bytes and one auxiliary byte into holding registers, then writes a control byte. That write launches one complete SPI transaction: chip select falls, the selected bytes are shifted out most significant bit first, an optional response of one to three bytes is clocked in, and chip select rises again.

The control byte packs three things: a start code in its upper nibble, which also picks one of two serial clock rates, a response byte count, and a 2-bit code that selects one of four outgoing frame shapes (1, 2, 4 or 5 bytes). Address bytes sit in the window in reverse wire order, so the byte sent first lives at the highest address offset. While a transaction runs, bit 7 of offset 0 reads as 1 and further control writes are dropped.

Top module: `spi_cmd_engine`

## Requirements
- R1: Bit 7 of offset 0 reads 1 from the clock edge that accepts a start until the transaction ends and 0 otherwise; bits [3:0] of offset 0 read back the response count and frame code of the last accepted start, bits [6:4] read 0.
- R2: Control bits [1:0] select the outgoing bytes in wire order: code 0 sends offset 1; code 1 sends offset 1 then offset 7; code 2 sends offset 1, 4, 3, 2; code 3 sends offset 1, 4, 3, 2, 7.
- R3: Control bits [3:2] give 0 to 3 response bytes clocked after the outgoing bytes; the k-th received byte reads at offset 5+k, and offsets 5 to 7 for bytes not received in the latest transaction read 0.
- R4: Upper nibble 5 starts with an SCK period of FAST_DIV system clocks (default 2); upper nibble 4 starts with SLOW_DIV system clocks (default 4).
- R5: A control write whose upper nibble is neither 4 nor 5 starts nothing: busy stays 0, chip select stays high and offset 0 bits [3:0] keep their value.
- R6: A control write while busy has no effect on the running transaction, its length, or offset 0 bits [3:0].
- R7: SPI mode 0: SCK idles low, bytes go out MSB first, MOSI changes only while SCK is low, MISO is sampled on the SCK rising edge, and MOSI is 0 during response bits.
- R8: Chip select is low for the whole transaction; the first SCK rising edge comes three SCK half-periods after chip select falls, chip select rises two half-periods after the last SCK falling edge, and busy lasts one SCK period per bit plus two.
- R9: Offsets 1 to 4 read back the last value written; a write to offset 7 sets the auxiliary outgoing byte while reads of offset 7 return the third response slot.
- R10: After synchronous reset all eight offsets read 0, chip select is high, and SCK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed offset |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A wrong sequencer state shows at the pins within one SCK half-period: a lost or extra bit moves the final SCK edge and stretches or shortens the busy window, which the bench measures in system clocks against the per-bit formula. A wrong frame assembly shows as a captured MOSI stream whose byte order differs from the offset order the frame code names, visible as soon as the transaction ends. Misplaced response bits show at offsets 5 to 7 on the first read after busy drops, and stale slots are exposed by following a long read with a shorter one.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BYTE_W      = 8;
    localparam int WIN_AW      = 3;
    localparam int RESP_SLOTS  = 3;
    localparam int FRAME_BYTES = 5;
    localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
    localparam int BITCNT_W    = $clog2((FRAME_BYTES + RESP_SLOTS) * BYTE_W + 1);
    localparam int RXCNT_W     = $clog2(RESP_SLOTS * BYTE_W + 1);

    localparam logic [WIN_AW-1:0] OFS_CTRL    = 3'd0;
    localparam logic [WIN_AW-1:0] OFS_OPC     = 3'd1;
    localparam logic [WIN_AW-1:0] OFS_ADR_LO  = 3'd2;
    localparam logic [WIN_AW-1:0] OFS_ADR_MID = 3'd3;
    localparam logic [WIN_AW-1:0] OFS_ADR_HI  = 3'd4;
    localparam logic [WIN_AW-1:0] OFS_RESP0   = 3'd5;
    localparam logic [WIN_AW-1:0] OFS_RESP1   = 3'd6;
    localparam logic [WIN_AW-1:0] OFS_AUX     = 3'd7;

    localparam logic [3:0] GO_SLOW = 4'h4;
    localparam logic [3:0] GO_FAST = 4'h5;

    typedef enum logic [1:0] {
        LEN_1 = 2'd0,
        LEN_2 = 2'd1,
        LEN_4 = 2'd2,
        LEN_5 = 2'd3
    } tx_len_e;

    typedef struct packed {
        logic [1:0] rx_cnt;
        tx_len_e    tx_len;
    } len_cfg_t;

    typedef struct packed {
        logic [3:0] go;
        len_cfg_t   cfg;
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] opc;
        logic [BYTE_W-1:0] adr_hi;
        logic [BYTE_W-1:0] adr_mid;
        logic [BYTE_W-1:0] adr_lo;
        logic [BYTE_W-1:0] aux;
    } cmd_bytes_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_SHIFT,
        SQ_TRAIL
    } seq_state_e;

    function automatic logic go_valid(input logic [3:0] go);
        return (go == GO_FAST) || (go == GO_SLOW);
    endfunction

    function automatic int tx_byte_count(input tx_len_e len);
        case (len)
            LEN_1:   return 1;
            LEN_2:   return 2;
            LEN_4:   return 4;
            default: return 5;
        endcase
    endfunction

    // Left-aligned outgoing frame; wire order is opcode first.
    function automatic logic [FRAME_W-1:0] build_frame(input cmd_bytes_t b, input tx_len_e len);
        case (len)
            LEN_1:   return {b.opc, {(4*BYTE_W){1'b0}}};
            LEN_2:   return {b.opc, b.aux, {(3*BYTE_W){1'b0}}};
            LEN_4:   return {b.opc, b.adr_hi, b.adr_mid, b.adr_lo, {BYTE_W{1'b0}}};
            default: return {b.opc, b.adr_hi, b.adr_mid, b.adr_lo, b.aux};
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WIN_AW-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata,
    input  logic                 busy,
    input  logic                 resp_we,
    input  logic [1:0]           resp_idx,
    input  logic [BYTE_W-1:0]    resp_byte,
    output logic                 start,
    output ctrl_t                ctrl_wr,
    output cmd_bytes_t           cmd_q
);

    len_cfg_t          cfg_q;
    logic [BYTE_W-1:0] resp_q [RESP_SLOTS];

    assign ctrl_wr = ctrl_t'(wdata);
    assign start   = wr_en && (addr == OFS_CTRL) && !busy && go_valid(ctrl_wr.go);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cmd_q <= '0;
        end else begin
            if (start) cfg_q <= ctrl_wr.cfg;
            if (wr_en) begin
                case (addr)
                    OFS_OPC:     cmd_q.opc     <= wdata;
                    OFS_ADR_LO:  cmd_q.adr_lo  <= wdata;
                    OFS_ADR_MID: cmd_q.adr_mid <= wdata;
                    OFS_ADR_HI:  cmd_q.adr_hi  <= wdata;
                    OFS_AUX:     cmd_q.aux     <= wdata;
                    default: ;
                endcase
            end
        end
    end

    generate
        for (genvar s = 0; s < RESP_SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst || start)
                    resp_q[s] <= '0;
                else if (resp_we && (resp_idx == 2'(s)))
                    resp_q[s] <= resp_byte;
            end
        end
    endgenerate

    always_comb begin
        case (addr)
            OFS_CTRL:    rdata = {busy, 3'b000, cfg_q};
            OFS_OPC:     rdata = cmd_q.opc;
            OFS_ADR_LO:  rdata = cmd_q.adr_lo;
            OFS_ADR_MID: rdata = cmd_q.adr_mid;
            OFS_ADR_HI:  rdata = cmd_q.adr_hi;
            OFS_RESP0:   rdata = resp_q[0];
            OFS_RESP1:   rdata = resp_q[1];
            default:     rdata = resp_q[2];
        endcase
    end

    // R6: control writes during a transaction leave the stored lengths alone
    a_r6_ctrl_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CTRL && busy) |=> $stable(cfg_q));

    // R5: an unknown start code from idle keeps the engine idle
    a_r5_bad_go_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CTRL && !busy && !go_valid(wdata[7:4])) |=> (!busy && $stable(cfg_q)));

    // R3: every accepted start empties the response slots
    a_r3_slots_cleared: assert property (@(posedge clk) disable iff (rst)
        start |=> (resp_q[0] == '0 && resp_q[1] == '0 && resp_q[2] == '0));

endmodule

// File: rtl/spi_cmd_clkgen.sv
module spi_cmd_clkgen #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int FAST_HALF = FAST_DIV / 2;
    localparam int SLOW_HALF = SLOW_DIV / 2;
    localparam int MAX_HALF  = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CNT_W     = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;
    localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_HALF - 1);
    localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_HALF - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = fast ? FAST_LIM : SLOW_LIM;
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R4: in slow mode half-period ticks are never back to back
    a_r4_slow_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && !fast && SLOW_HALF > 1) |=> !tick);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ctrl_t             ctrl_in,
    input  cmd_bytes_t        cmd,
    input  logic              tick,
    output logic              busy,
    output logic              fast_q,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              resp_we,
    output logic [1:0]        resp_idx,
    output logic [BYTE_W-1:0] resp_byte
);

    seq_state_e           state;
    logic [FRAME_W-1:0]   txsh;
    logic [BITCNT_W-1:0]  bitcnt;
    logic [BITCNT_W-1:0]  last_bit;
    logic [BITCNT_W-1:0]  tx_bits;
    logic [BYTE_W-2:0]    rxsh;
    logic [RXCNT_W-1:0]   rxcnt;
    logic                 phase;
    logic                 in_rx;
    logic                 rise_tick;

    assign busy      = (state != SQ_IDLE);
    assign mosi      = txsh[FRAME_W-1];
    assign in_rx     = (bitcnt >= tx_bits);
    assign rise_tick = (state == SQ_SHIFT) && tick && !sck;
    assign resp_we   = rise_tick && in_rx && (rxcnt[2:0] == 3'd7);
    assign resp_idx  = rxcnt[4:3];
    assign resp_byte = {rxsh, miso};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            txsh     <= '0;
            bitcnt   <= '0;
            last_bit <= '0;
            tx_bits  <= '0;
            rxsh     <= '0;
            rxcnt    <= '0;
            phase    <= 1'b0;
            sck      <= 1'b0;
            cs_n     <= 1'b1;
            fast_q   <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        txsh     <= build_frame(cmd, ctrl_in.cfg.tx_len);
                        tx_bits  <= BITCNT_W'(tx_byte_count(ctrl_in.cfg.tx_len) * BYTE_W);
                        last_bit <= BITCNT_W'((tx_byte_count(ctrl_in.cfg.tx_len)
                                              + int'(ctrl_in.cfg.rx_cnt)) * BYTE_W - 1);
                        bitcnt   <= '0;
                        rxcnt    <= '0;
                        phase    <= 1'b0;
                        fast_q   <= (ctrl_in.go == GO_FAST);
                        cs_n     <= 1'b0;
                        state    <= SQ_LEAD;
                    end
                end
                SQ_LEAD: begin
                    if (tick) begin
                        phase <= !phase;
                        if (phase) state <= SQ_SHIFT;
                    end
                end
                SQ_SHIFT: begin
                    if (tick) begin
                        if (!sck) begin
                            sck <= 1'b1;
                            if (in_rx) begin
                                rxsh  <= {rxsh[BYTE_W-3:0], miso};
                                rxcnt <= rxcnt + 1'b1;
                            end
                        end else begin
                            sck  <= 1'b0;
                            txsh <= txsh << 1;
                            if (bitcnt == last_bit)
                                state <= SQ_TRAIL;
                            else
                                bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        phase <= !phase;
                        if (phase) begin
                            state <= SQ_IDLE;
                            cs_n  <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R7: data out is never changed while the serial clock is high
    a_r7_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));

    // R7: the serial clock stays low whenever chip select is released
    a_r7_sck_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R8: the bit counter never runs past the frame end
    a_r8_bit_bound: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SHIFT) |-> (bitcnt <= last_bit));

    // R8: chip select is released only out of the trailing phase
    a_r8_cs_release: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> ($past(state) == SQ_TRAIL));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [WIN_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic              start;
    ctrl_t             ctrl_wr;
    cmd_bytes_t        cmd_q;
    logic              busy;
    logic              fast_q;
    logic              tick;
    logic              resp_we;
    logic [1:0]        resp_idx;
    logic [BYTE_W-1:0] resp_byte;

    spi_cmd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (busy),
        .resp_we   (resp_we),
        .resp_idx  (resp_idx),
        .resp_byte (resp_byte),
        .start     (start),
        .ctrl_wr   (ctrl_wr),
        .cmd_q     (cmd_q)
    );

    spi_cmd_clkgen #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .fast (fast_q),
        .tick (tick)
    );

    spi_cmd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ctrl_in   (ctrl_wr),
        .cmd       (cmd_q),
        .tick      (tick),
        .busy      (busy),
        .fast_q    (fast_q),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .miso      (spi_miso),
        .resp_we   (resp_we),
        .resp_idx  (resp_idx),
        .resp_byte (resp_byte)
    );

    // R1: the busy bit seen through the window matches an asserted chip select
    a_r1_busy_visible: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && reg_addr == OFS_CTRL) |-> reg_rdata[7]);

endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  opc;
        logic [7:0]  hi;
        logic [7:0]  mid;
        logic [7:0]  lo;
        logic [7:0]  aux;
        logic [23:0] resp;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'h50, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 24'h000000},
        '{8'h5C, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 24'hC22017},
        '{8'h44, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 24'h5A0000},
        '{8'h41, 8'h01, 8'h00, 8'h00, 8'h00, 8'h3C, 24'h000000},
        '{8'h56, 8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 24'hA50000},
        '{8'h4B, 8'h02, 8'hAB, 8'hCD, 8'hEF, 8'h77, 24'h817E00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [63:0] pat = '0;
    logic [63:0] cap = '0;
    int nrise = 0;
    int t_csf = 0, t_csr = 0, t_r1 = 0, t_r2 = 0, t_lastf = 0;

    spi_cmd_engine u_spi_cmd_engine (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Device model: presents pattern bits, captures MOSI on rising SCK
    always @(negedge spi_cs_n) begin
        t_csf = cyc;
        spi_miso = pat[63];
    end
    always @(posedge spi_cs_n) t_csr = cyc;
    always @(posedge spi_sck) begin
        cap = {cap[62:0], spi_mosi};
        nrise = nrise + 1;
        if (nrise == 1) t_r1 = cyc;
        if (nrise == 2) t_r2 = cyc;
    end
    always @(negedge spi_sck) begin
        t_lastf = cyc;
        if (nrise < 64) spi_miso = pat[63 - nrise];
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Counts negedges with busy set; write of ctrl must just have been issued
    task automatic wait_idle(output int n);
        n = 0;
        reg_addr = 3'd0;
        #1;
        while (reg_rdata[7] && n < 5000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    function automatic int txb(input logic [1:0] code);
        case (code)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 5;
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int ntx, nrx, nbits, h, n;
        logic [63:0] exp_frame, mask;
        logic [7:0] d;
        ntx = txb(v.ctrl[1:0]);
        nrx = int'(v.ctrl[3:2]);
        nbits = (ntx + nrx) * 8;
        h = (v.ctrl[7:4] == 4'h5) ? 1 : 2;
        wr(3'd1, v.opc);
        wr(3'd4, v.hi);
        wr(3'd3, v.mid);
        wr(3'd2, v.lo);
        wr(3'd7, v.aux);
        pat = ~(64'hFFFF_FFFF_FFFF_FFFF >> (ntx * 8)) | ({v.resp, 40'h0} >> (ntx * 8));
        cap = '0;
        nrise = 0;
        wr(3'd0, v.ctrl);
        wait_idle(n);
        chk("R8", "busy cycles", 64'(n), 64'(2 * h * (nbits + 2)));
        chk("R4", "sck period", 64'(t_r2 - t_r1), 64'(2 * h));
        chk("R8", "cs lead", 64'(t_r1 - t_csf), 64'(3 * h));
        chk("R8", "cs trail", 64'(t_csr - t_lastf), 64'(2 * h));
        chk("R7", "rising edges", 64'(nrise), 64'(nbits));
        exp_frame = 64'(v.opc);
        if (v.ctrl[1:0] == 2'd1) exp_frame = (exp_frame << 8) | 64'(v.aux);
        if (v.ctrl[1]) exp_frame = (exp_frame << 24) | {40'h0, v.hi, v.mid, v.lo};
        if (v.ctrl[1:0] == 2'd3) exp_frame = (exp_frame << 8) | 64'(v.aux);
        exp_frame = exp_frame << (8 * nrx);
        mask = (nbits == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << nbits) - 64'd1);
        chk("R2", "mosi frame", cap & mask, exp_frame);
        for (int k = 0; k < 3; k++) begin
            rd(3'(5 + k), d);
            chk("R3", "response slot", 64'(d), (k < nrx) ? 64'(v.resp[23 - 8*k -: 8]) : 64'h0);
        end
        rd(3'd0, d);
        chk("R1", "ctrl readback", 64'(d), 64'({4'h0, v.ctrl[3:0]}));
    endtask

    initial begin
        int n;
        logic [7:0] d;
        for (int i = 0; i < 4; i++) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R10", "offset after reset", 64'(d), 64'h0);
        end
        chk("R10", "cs_n after reset", 64'(spi_cs_n), 64'h1);
        chk("R10", "sck/mosi after reset", 64'({spi_sck, spi_mosi}), 64'h0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R9: readback of holding registers, offset 7 reads third slot (0 for 2-byte read)
        rd(3'd1, d); chk("R9", "offset 1", 64'(d), 64'h02);
        rd(3'd4, d); chk("R9", "offset 4", 64'(d), 64'hAB);
        rd(3'd3, d); chk("R9", "offset 3", 64'(d), 64'hCD);
        rd(3'd2, d); chk("R9", "offset 2", 64'(d), 64'hEF);
        rd(3'd7, d); chk("R9", "offset 7 read", 64'(d), 64'h00);

        // R5: invalid start codes leave engine idle
        wr(3'd0, 8'h3D);
        rd(3'd0, d);
        chk("R5", "bad code 3", 64'(d), 64'h0B);
        chk("R5", "cs after bad code", 64'(spi_cs_n), 64'h1);
        wr(3'd0, 8'h60);
        rd(3'd0, d);
        chk("R5", "bad code 6", 64'(d), 64'h0B);

        // R6: control write during busy ignored (slow 1 tx + 1 rx => 2*2*(16+2) = 72)
        pat = {8'hFF, 8'h3E, 48'h0};
        nrise = 0;
        wr(3'd0, 8'h44);
        for (int i = 0; i < 4; i++) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h5F;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_idle(n);
        chk("R6", "busy cycles with mid write", 64'(n + 5), 64'd72);
        chk("R6", "edges with mid write", 64'(nrise), 64'd16);
        rd(3'd0, d);
        chk("R6", "ctrl after mid write", 64'(d), 64'h04);
        rd(3'd5, d);
        chk("R3", "slot0 after short read", 64'(d), 64'h3E);
        rd(3'd6, d);
        chk("R3", "slot1 cleared", 64'(d), 64'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL R8 watchdog actual=%0d expected<%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule